// File: doc/BRIEF.md
# Rate-Selectable Ten-Bit Serializer

This block turns a stream of 10-bit transmission characters into a single serial bit stream. It runs on one fast core clock that stands in for the transmit oscillator. A rate input chooses between two speeds. At full rate one bit leaves on every core clock cycle. At half rate the core clock is divided by two, so each bit lasts two cycles. The characters are expected to be DC-balanced 8b/10b code groups. The block sends every bit unchanged and does no coding of its own.

Characters follow one another with no gap. The upstream source sees a one-cycle take strobe in the cycle whose clock edge captures the next character. The block also produces two derived clocks. The first is a word clock that always runs at one tenth of the serial bit rate. The second is a reference-phase clock whose period is set by a divider input: either the same as the word clock, or half its frequency. Setting the divider never changes the word clock.

Top module: `rate_serializer`

## Requirements
- R1: Each 10-bit character is sent as 10 consecutive serial bits, bit 0 first and bit 9 last, with values unchanged.
- R2: With the rate input low (0), consecutive bits of a character appear one core clock cycle apart.
- R3: With the rate input high (1), consecutive bits of a character appear two core clock cycles apart.
- R4: The rate input is sampled only in the cycle the take strobe is high. A change in the middle of a character does not alter that character's bit spacing.
- R5: Bit 0 of the next character follows bit 9 of the current one after exactly one bit period. The take strobe is high for one cycle, and the clock edge ending that cycle captures the character input.
- R6: The word clock is high while bits 0 to 4 of each character are on the line and low while bits 5 to 9 are on the line, for either divider setting.
- R7: With the divider input low (/10), the reference clock follows the same pattern as the word clock. With it high (/20), the reference clock is high for the whole of the 1st, 3rd, 5th and later odd-numbered characters after reset, and low for the whole of the even-numbered ones. The divider input is sampled together with each character.
- R8: Synchronous active-high reset clears the serial output, the word clock and the reference clock, and restarts the bit counter at 0 at full rate. The take strobe is then high in the first cycle after reset.
- R9: The bit-enable output is high on every cycle at full rate. At half rate it alternates, being low in the cycle after each bit starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock modelling the transmit oscillator |
| rst | input | 1 | Synchronous active-high reset |
| rate_half_i | input | 1 | 0 = full rate, 1 = half rate; sampled at character boundaries |
| ref_div20_i | input | 1 | 0 = reference at serial/10, 1 = reference at serial/20 |
| char_i | input | 10 | Character to send next |
| char_take_o | output | 1 | High in the cycle whose edge captures char_i |
| bit_en_o | output | 1 | Bit-period strobe derived from the core clock |
| ser_o | output | 1 | Serial data output |
| word_clk_o | output | 1 | Word-rate clock at serial/10, high for 5 bits and low for 5 |
| ref_clk_o | output | 1 | Reference-phase clock at serial/10 or serial/20 |

## Verification
The hardest case to reach from the ports is a rate change that arrives partway through a character, because the block must ignore it until the next boundary. The stimulus flips the rate input after bit 4 of a character has been observed. It then measures that character's bit spacing against the rate it started with. The rate and divider settings are also switched at consecutive boundaries in both directions, and a reset is forced in the middle of a character. Gap-free joins and the alternating reference phase are checked across each of these transitions.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int CHAR_W = 10;

    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;

    typedef enum logic {
        REF_DIV10 = 1'b0,
        REF_DIV20 = 1'b1
    } refdiv_e;

    function automatic int cnt_bits(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/ser_rate_div.sv
module ser_rate_div
    import ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic rate_half_i,
    output logic bit_en_o,
    output logic rate_act_o
);

    rate_e rate_act;
    logic  phase;

    assign bit_en_o   = (rate_act == RATE_FULL) || phase;
    assign rate_act_o = (rate_act == RATE_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_act <= RATE_FULL;
            phase    <= 1'b0;
        end else begin
            phase <= !bit_en_o;
            if (load_i) begin
                rate_act <= rate_half_i ? RATE_HALF : RATE_FULL;
            end
        end
    end

endmodule

// File: rtl/ser_shift.sv
module ser_shift
    import ser_pkg::*;
#(
    parameter int W         = CHAR_W,
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en_i,
    input  logic [W-1:0]            char_i,
    output logic                    take_o,
    output logic                    ser_o,
    output logic [cnt_bits(W)-1:0]  cnt_o
);

    localparam int CW = cnt_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic [W-1:0]  shifted;

    generate
        if (LSB_FIRST) begin : g_lsb
            assign shifted = {1'b0, shreg[W-1:1]};
            assign ser_o   = shreg[0];
        end else begin : g_msb
            assign shifted = {shreg[W-2:0], 1'b0};
            assign ser_o   = shreg[W-1];
        end
    endgenerate

    assign take_o = bit_en_i && (cnt == '0);
    assign cnt_o  = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (bit_en_i) begin
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            shreg <= take_o ? char_i : shifted;
        end
    end

endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen
    import ser_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_en_i,
    input  logic                   take_i,
    input  logic [cnt_bits(W)-1:0] cnt_i,
    input  logic                   ref_div20_i,
    output logic                   word_clk_o,
    output logic                   ref_clk_o
);

    localparam int CW = cnt_bits(W);
    localparam logic [CW-1:0] HALF = CW'(W / 2);

    refdiv_e ref_act;
    logic    ref_half;
    logic    first_half;

    assign first_half = (cnt_i < HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_clk_o <= 1'b0;
            ref_clk_o  <= 1'b0;
            ref_act    <= REF_DIV10;
            ref_half   <= 1'b0;
        end else if (bit_en_i) begin
            word_clk_o <= first_half;
            if (take_i) begin
                ref_act   <= ref_div20_i ? REF_DIV20 : REF_DIV10;
                ref_half  <= !ref_half;
                ref_clk_o <= ref_div20_i ? !ref_half : 1'b1;
            end else if (ref_act == REF_DIV10) begin
                ref_clk_o <= first_half;
            end
        end
    end

endmodule

// File: rtl/rate_serializer.sv
module rate_serializer
    import ser_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rate_half_i,
    input  logic         ref_div20_i,
    input  logic [W-1:0] char_i,
    output logic         char_take_o,
    output logic         bit_en_o,
    output logic         ser_o,
    output logic         word_clk_o,
    output logic         ref_clk_o
);

    localparam int CW = cnt_bits(W);

    logic          bit_en;
    logic          take;
    logic          rate_act;
    logic [CW-1:0] cnt;

    ser_rate_div u_div (
        .clk        (clk),
        .rst        (rst),
        .load_i     (take),
        .rate_half_i(rate_half_i),
        .bit_en_o   (bit_en),
        .rate_act_o (rate_act)
    );

    ser_shift #(.W(W), .LSB_FIRST(1'b1)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_en_i(bit_en),
        .char_i  (char_i),
        .take_o  (take),
        .ser_o   (ser_o),
        .cnt_o   (cnt)
    );

    ser_clkgen #(.W(W)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .bit_en_i   (bit_en),
        .take_i     (take),
        .cnt_i      (cnt),
        .ref_div20_i(ref_div20_i),
        .word_clk_o (word_clk_o),
        .ref_clk_o  (ref_clk_o)
    );

    assign char_take_o = take;
    assign bit_en_o    = bit_en;

endmodule

// File: rtl/rate_serializer_chk.sv
module rate_serializer_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         bit_en,
    input logic         take,
    input logic         ser,
    input logic         word_clk,
    input logic         rate_act,
    input logic [W-1:0] char_in
);

    // R1
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (ser == $past(char_in[0])));

    // R3
    half_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_act && bit_en && !take) |=> !bit_en);

    // R4
    rate_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(rate_act)) |-> $past(take));

    // R6
    word_high_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> word_clk);

    // R6
    word_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> $past(take));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!word_clk && !ser && take));

endmodule

bind rate_serializer rate_serializer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en_o),
    .take    (char_take_o),
    .ser     (ser_o),
    .word_clk(word_clk_o),
    .rate_act(rate_act),
    .char_in (char_i)
);

// File: tb/rate_serializer_bench.sv
module rate_serializer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_half_i = 1'b0;
    logic       ref_div20_i = 1'b0;
    logic [9:0] char_i = '0;
    logic       char_take_o, bit_en_o, ser_o, word_clk_o, ref_clk_o;

    int tests = 0;
    int fails = 0;
    int loads = 0;
    int prev_p = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rate_serializer u_rate_serializer (
        .clk        (clk),
        .rst        (rst),
        .rate_half_i(rate_half_i),
        .ref_div20_i(ref_div20_i),
        .char_i     (char_i),
        .char_take_o(char_take_o),
        .bit_en_o   (bit_en_o),
        .ser_o      (ser_o),
        .word_clk_o (word_clk_o),
        .ref_clk_o  (ref_clk_o)
    );

    // {rate_half, ref_div20, character}
    localparam logic [11:0] VEC [10] = '{
        {1'b0, 1'b0, 10'h17C},
        {1'b0, 1'b0, 10'h283},
        {1'b1, 1'b0, 10'h2AA},
        {1'b1, 1'b0, 10'h0F9},
        {1'b0, 1'b1, 10'h305},
        {1'b0, 1'b1, 10'h1C6},
        {1'b1, 1'b1, 10'h355},
        {1'b1, 1'b1, 10'h0AB},
        {1'b0, 1'b0, 10'h3E0},
        {1'b1, 1'b1, 10'h01F}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        loads = 0;
        prev_p = 1;
        // R8: cleared outputs and immediate take after reset
        chk(ser_o == 1'b0, "R8 ser_o after reset", 32'(ser_o), 0);
        chk(word_clk_o == 1'b0 && ref_clk_o == 1'b0, "R8 clocks after reset",
            {30'd0, word_clk_o, ref_clk_o}, 0);
        chk(char_take_o == 1'b1, "R8 take after reset", 32'(char_take_o), 1);
    endtask

    // Called at a negedge. Sends one character and checks it.
    task automatic run_char(input bit rate, input bit refsel, input logic [9:0] ch, input bit mid_flip);
        int waits = 0;
        int span = 0;
        int p;
        logic [9:0] bits, wc, rc, exp_rc;
        bit en_ok = 1'b1;
        while (!char_take_o) begin
            @(negedge clk);
            waits++;
        end
        // R5: no gap between characters
        chk(waits == prev_p - 1, "R5 join gap", 32'(waits), 32'(prev_p - 1));
        rate_half_i = rate;
        ref_div20_i = refsel;
        char_i = ch;
        loads++;
        p = rate ? 2 : 1;
        @(negedge clk);
        bits[0] = ser_o; wc[0] = word_clk_o; rc[0] = ref_clk_o;
        if (bit_en_o != (p == 1)) en_ok = 1'b0;
        for (int k = 1; k < 10; k++) begin
            while (!bit_en_o) begin
                @(negedge clk);
                span++;
            end
            @(negedge clk);
            span++;
            bits[k] = ser_o; wc[k] = word_clk_o; rc[k] = ref_clk_o;
            if (bit_en_o != (p == 1)) en_ok = 1'b0;
            if (mid_flip && k == 4) rate_half_i = !rate_half_i;
        end
        char_i = ~ch;
        // R1
        chk(bits == ch, "R1 serial bits", 32'(bits), 32'(ch));
        if (mid_flip)
            chk(span == 9 * p, "R4 span after mid-character rate flip", 32'(span), 32'(9 * p));
        else if (rate)
            chk(span == 18, "R3 half-rate span", 32'(span), 18);
        else
            chk(span == 9, "R2 full-rate span", 32'(span), 9);
        // R9
        chk(en_ok, "R9 bit enable pattern", 32'(en_ok), 1);
        // R6
        chk(wc == 10'h01F, "R6 word clock", 32'(wc), 32'h01F);
        exp_rc = refsel ? ((loads % 2 == 1) ? 10'h3FF : 10'h000) : 10'h01F;
        // R7
        chk(rc == exp_rc, "R7 reference clock", 32'(rc), 32'(exp_rc));
        prev_p = p;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        foreach (VEC[i]) begin
            run_char(VEC[i][11], VEC[i][10], VEC[i][9:0], 1'b0);
        end
        // R4: rate flips mid-character in both directions
        run_char(1'b0, 1'b0, 10'h2D1, 1'b1);
        run_char(1'b1, 1'b0, 10'h13A, 1'b1);
        run_char(1'b0, 1'b1, 10'h3C3, 1'b0);
        // R8: reset in the middle of a half-rate character
        while (!char_take_o) @(negedge clk);
        rate_half_i = 1'b1;
        char_i = 10'h3FF;
        repeat (7) @(negedge clk);
        do_reset();
        run_char(1'b0, 1'b1, 10'h0C7, 1'b0);
        run_char(1'b1, 1'b1, 10'h238, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule